// File: doc/BRIEF.md
# Logic-Cell Probe and Flip-Flop Write Window

This block sits between a microcontroller data bus and a 16x16 grid of logic cells. It gives the processor a 256-location window. A read samples cell outputs in real time. A write forces a nibble into one context of a cell's flip-flops. Each cell exposes a 4-bit combinational output and a 4-bit registered output, and it holds two flip-flop contexts.

The window covers one 8x8 quarter of the grid at a time, chosen by a 2-bit quarter code. A 2-bit access code selects how bytes are packed:
- **Single-cell:** one cell per byte, with the registered nibble above the combinational nibble.
- **Horizontal pair:** two neighbouring cells per byte, counted along a row.
- **Vertical pair:** two neighbouring cells per byte, counted along a column.

In both pair modes the top address bit splits the window. On reads it picks combinational or registered outputs. On writes it picks context 0 or context 1.

The block decodes address and data into per-cell load strobes and per-cell write nibbles for the cell array, and it multiplexes the array's outputs into a registered read byte. Two parameters give how many rows and columns of the grid are really populated. Cells outside that region are never loaded and read as zero.

Top module: `cellwin_probe_window`

## Requirements
- R1: While rst_ni is low, rdata_o is 8'h00.
- R2: rdata_o changes only at the rising edge where rd_i is high, taking the byte addressed in that cycle. The byte reflects cell outputs as they were before that edge. With rd_i low, rdata_o holds.
- R3: With mode_i[1]=0, addr_i[5:0] selects one tile cell k. The local row is k[5:3], counted from the south. The local column is k[2:0], counted from the east. rdata is {registered nibble, combinational nibble}.
- R4: With mode_i=2'b10, p=addr_i[4:0] selects tile cells 2p (low nibble) and 2p+1 (high nibble). These cells use the row/column numbering of R3. addr_i[7]=0 returns combinational nibbles; addr_i[7]=1 returns registered nibbles.
- R5: With mode_i=2'b11, numbering and halves are as in R4, except that k[2:0] is the local row and k[5:3] is the local column.
- R6: Quarter code 00 is always the south-east quarter. In single and horizontal modes, quarter_i[0] selects the west half and quarter_i[1] selects the north half. In vertical mode, quarter_i[0] selects north and quarter_i[1] selects west. Global cell index = 16*row + col, with row 0 south and col 0 east.
- R7: A single-mode write (mode 00 for context 0, 01 for context 1) loads wdata_i[3:0] into exactly one cell. ff_ctx_o equals mode_i[0].
- R8: A pair-mode write loads wdata_i[3:0] into the low cell and wdata_i[7:4] into the high cell. addr_i[7]=0 targets context 0 and addr_i[7]=1 targets context 1.
- R9: A cell with global row >= POP_ROWS or global column >= POP_COLS never receives a load strobe, and its nibble reads as 0.
- R10: A location outside the tile loads nothing and reads as 8'h00. For single mode that is addr_i[7:6] != 0. For pair modes that is addr_i[6:5] != 0.
- R11: Load strobes follow wr_i in the same cycle, so the cell takes the nibble at the next rising edge. With wr_i low, no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Window location |
| mode_i | input | 2 | Access code: 0X single, 10 horizontal pair, 11 vertical pair |
| quarter_i | input | 2 | Quarter select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Registered read byte |
| comb_i | input | 1024 | Combinational nibble of each cell, cell i at bits 4i+3:4i |
| seq_i | input | 1024 | Registered nibble of each cell, same layout |
| ff_load_o | output | 256 | Per-cell flip-flop load strobe |
| ff_data_o | output | 1024 | Per-cell nibble to load, same layout as comb_i |
| ff_ctx_o | output | 1 | Context targeted by the load (0 or 1) |

## Verification
A read and a write can hit the same cell in the same cycle. The read must capture the registered nibble as it was before the edge, while the write lands at that same edge. The bench raises rd_i and wr_i together on one single-mode location. It predicts the byte from the cell model before the edge, then reads again to confirm the new nibble. A pair write that ends up in a different context from the one being probed is also checked by reading the unchanged context-0 value back.

// File: rtl/cellwin_pkg.sv
package cellwin_pkg;
  localparam int unsigned GRID   = 16;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned CELLS  = GRID * GRID;
  localparam int unsigned IDX_W  = $clog2(CELLS);
  localparam int unsigned TILE   = GRID / 2;
  localparam int unsigned TC_W   = $clog2(TILE);
  localparam int unsigned TK_W   = 2 * TC_W;
  localparam int unsigned WIN_AW = IDX_W;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    ACC_SINGLE0 = 2'b00,
    ACC_SINGLE1 = 2'b01,
    ACC_HPAIR   = 2'b10,
    ACC_VPAIR   = 2'b11
  } acc_mode_e;

  typedef struct packed {
    logic            ok;
    logic [TC_W:0]   row;
    logic [TC_W:0]   col;
  } cell_ref_t;

  function automatic logic [IDX_W-1:0] ref_idx(cell_ref_t r);
    return {r.row, r.col};
  endfunction
endpackage

// File: rtl/cellwin_addr_map.sv
module cellwin_addr_map import cellwin_pkg::*; #(
  parameter int unsigned POP_ROWS = GRID,
  parameter int unsigned POP_COLS = GRID
) (
  input  logic [WIN_AW-1:0] addr_i,
  input  acc_mode_e         mode_i,
  input  logic [1:0]        quarter_i,
  output cell_ref_t         lo_o,
  output cell_ref_t         hi_o,
  output logic              paired_o,
  output logic              half_o
);
  logic            vert;
  logic            in_range;
  logic [TK_W-1:0] k_lo, k_hi;

  // tile cell k -> global row/col; vertical order swaps both k halves and quarter bits
  function automatic cell_ref_t map_cell(logic [TK_W-1:0] k, logic v,
                                         logic [1:0] q, logic rng);
    cell_ref_t       r;
    logic [TC_W-1:0] lr, lc;
    logic            qr, qc;
    if (v) begin
      lc = k[TK_W-1:TC_W];
      lr = k[TC_W-1:0];
      qr = q[0];
      qc = q[1];
    end else begin
      lr = k[TK_W-1:TC_W];
      lc = k[TC_W-1:0];
      qr = q[1];
      qc = q[0];
    end
    r.row = {qr, lr};
    r.col = {qc, lc};
    r.ok  = rng && (32'(r.row) < POP_ROWS) && (32'(r.col) < POP_COLS);
    return r;
  endfunction

  always_comb begin
    paired_o = mode_i[1];
    vert     = (mode_i == ACC_VPAIR);
    half_o   = paired_o & addr_i[WIN_AW-1];
    if (paired_o) begin
      k_lo     = {addr_i[TK_W-2:0], 1'b0};
      k_hi     = {addr_i[TK_W-2:0], 1'b1};
      in_range = (addr_i[WIN_AW-2:TK_W-1] == '0);
    end else begin
      k_lo     = addr_i[TK_W-1:0];
      k_hi     = addr_i[TK_W-1:0];
      in_range = (addr_i[WIN_AW-1:TK_W] == '0);
    end
    lo_o = map_cell(k_lo, vert, quarter_i, in_range);
    hi_o = map_cell(k_hi, vert, quarter_i, in_range);
  end
endmodule

// File: rtl/cellwin_probe_rd.sv
module cellwin_probe_rd import cellwin_pkg::*; (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  cell_ref_t              lo_i,
  input  cell_ref_t              hi_i,
  input  logic                   paired_i,
  input  logic                   half_i,
  input  logic [CELLS*NIB_W-1:0] comb_i,
  input  logic [CELLS*NIB_W-1:0] seq_i,
  output logic [BYTE_W-1:0]      rdata_o
);
  logic [NIB_W-1:0]  c_lo, c_hi, s_lo, s_hi;
  logic [BYTE_W-1:0] byte_d;

  function automatic logic [NIB_W-1:0] pick(logic [CELLS*NIB_W-1:0] v, cell_ref_t r);
    return r.ok ? v[NIB_W*ref_idx(r) +: NIB_W] : '0;
  endfunction

  always_comb begin
    c_lo = pick(comb_i, lo_i);
    c_hi = pick(comb_i, hi_i);
    s_lo = pick(seq_i, lo_i);
    s_hi = pick(seq_i, hi_i);
    if (paired_i) byte_d = half_i ? {s_hi, s_lo} : {c_hi, c_lo};
    else          byte_d = {s_lo, c_lo};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= byte_d;
  end
endmodule

// File: rtl/cellwin_ff_load.sv
module cellwin_ff_load import cellwin_pkg::*; (
  input  logic                   wr_i,
  input  cell_ref_t              lo_i,
  input  cell_ref_t              hi_i,
  input  logic                   paired_i,
  input  logic                   half_i,
  input  acc_mode_e              mode_i,
  input  logic [BYTE_W-1:0]      wdata_i,
  output logic [CELLS-1:0]       ff_load_o,
  output logic [CELLS*NIB_W-1:0] ff_data_o,
  output logic                   ff_ctx_o
);
  assign ff_ctx_o = paired_i ? half_i : (mode_i == ACC_SINGLE1);

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    logic hit_lo, hit_hi;
    assign hit_lo = lo_i.ok && (ref_idx(lo_i) == IDX_W'(g));
    assign hit_hi = paired_i && hi_i.ok && (ref_idx(hi_i) == IDX_W'(g));
    assign ff_load_o[g] = wr_i && (hit_lo || hit_hi);
    assign ff_data_o[g*NIB_W +: NIB_W] =
      hit_hi ? wdata_i[BYTE_W-1:NIB_W] : wdata_i[NIB_W-1:0];
  end
endmodule

// File: rtl/cellwin_probe_window.sv
module cellwin_probe_window import cellwin_pkg::*; #(
  parameter int unsigned POP_ROWS = GRID,
  parameter int unsigned POP_COLS = GRID
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WIN_AW-1:0]      addr_i,
  input  logic [1:0]             mode_i,
  input  logic [1:0]             quarter_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [BYTE_W-1:0]      wdata_i,
  output logic [BYTE_W-1:0]      rdata_o,
  input  logic [CELLS*NIB_W-1:0] comb_i,
  input  logic [CELLS*NIB_W-1:0] seq_i,
  output logic [CELLS-1:0]       ff_load_o,
  output logic [CELLS*NIB_W-1:0] ff_data_o,
  output logic                   ff_ctx_o
);
  acc_mode_e mode;
  cell_ref_t lo_ref, hi_ref;
  logic      paired, half;

  assign mode = acc_mode_e'(mode_i);

  cellwin_addr_map #(.POP_ROWS(POP_ROWS), .POP_COLS(POP_COLS)) u_map (
    .addr_i   (addr_i),
    .mode_i   (mode),
    .quarter_i(quarter_i),
    .lo_o     (lo_ref),
    .hi_o     (hi_ref),
    .paired_o (paired),
    .half_o   (half)
  );

  cellwin_probe_rd u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .lo_i    (lo_ref),
    .hi_i    (hi_ref),
    .paired_i(paired),
    .half_i  (half),
    .comb_i  (comb_i),
    .seq_i   (seq_i),
    .rdata_o (rdata_o)
  );

  cellwin_ff_load u_ld (
    .wr_i     (wr_i),
    .lo_i     (lo_ref),
    .hi_i     (hi_ref),
    .paired_i (paired),
    .half_i   (half),
    .mode_i   (mode),
    .wdata_i  (wdata_i),
    .ff_load_o(ff_load_o),
    .ff_data_o(ff_data_o),
    .ff_ctx_o (ff_ctx_o)
  );

  p_hold_rdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_single_one_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !mode_i[1] |-> $onehot0(ff_load_o));

  p_pair_ctx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && mode_i[1] && (ff_load_o != '0) |-> ff_ctx_o == addr_i[WIN_AW-1]);

  p_pair_two_loads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && mode_i[1] |-> $countones(ff_load_o) <= 2);

  p_pair_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && mode_i[1] && (addr_i[WIN_AW-2:TK_W-1] != '0) |-> ff_load_o == '0);

  p_single_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !mode_i[1] && (addr_i[WIN_AW-1:TK_W] != '0) |-> ff_load_o == '0);

  p_idle_no_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> ff_load_o == '0);
endmodule

// File: tb/cellwin_probe_window_test.sv
module cellwin_probe_window_test;
  import cellwin_pkg::*;
  localparam int PR = 12;
  localparam int PC = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n;
  logic [WIN_AW-1:0]      addr;
  logic [1:0]             mode, quarter;
  logic                   rd, wr;
  logic [BYTE_W-1:0]      wdata, rdata;
  logic [CELLS*NIB_W-1:0] comb_bus, seq_bus, ld_data;
  logic [CELLS-1:0]       ld;
  logic                   ld_ctx;
  logic [NIB_W-1:0]       ff0 [CELLS];
  logic [NIB_W-1:0]       ff1 [CELLS];
  int checks = 0;
  int errors = 0;

  cellwin_probe_window #(.POP_ROWS(PR), .POP_COLS(PC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mode_i(mode), .quarter_i(quarter),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .comb_i(comb_bus), .seq_i(seq_bus),
    .ff_load_o(ld), .ff_data_o(ld_data), .ff_ctx_o(ld_ctx)
  );

  function automatic logic [3:0] comb_val(int i);
    return 4'((i % 16) + 7 * (i / 16) + 1);
  endfunction

  function automatic logic [3:0] init_val(int i);
    return 4'(i) ^ 4'h6;
  endfunction

  // cell array model
  always_comb
    for (int i = 0; i < CELLS; i++) begin
      comb_bus[i*4 +: 4] = comb_val(i);
      seq_bus[i*4 +: 4]  = ff0[i];
    end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) begin
        ff0[i] <= init_val(i);
        ff1[i] <= 4'h0;
      end
    end else begin
      for (int i = 0; i < CELLS; i++)
        if (ld[i]) begin
          if (ld_ctx) ff1[i] <= ld_data[i*4 +: 4];
          else        ff0[i] <= ld_data[i*4 +: 4];
        end
    end

  function automatic int cell_of(int lr, int lc, bit vert, logic [1:0] q);
    int qr = vert ? int'(q[0]) : int'(q[1]);
    int qc = vert ? int'(q[1]) : int'(q[0]);
    int gr = qr * TILE + lr;
    int gc = qc * TILE + lc;
    if (gr >= PR || gc >= PC) return -1;
    return gr * GRID + gc;
  endfunction

  function automatic logic [7:0] exp_byte(int a, logic [1:0] m, logic [1:0] q);
    logic [7:0] b = 8'h00;
    if (!m[1]) begin
      int c;
      if (a >= 64) return 8'h00;
      c = cell_of(a / 8, a % 8, 1'b0, q);
      if (c < 0) return 8'h00;
      return {ff0[c], comb_val(c)};
    end
    if (((a / 32) % 4) != 0) return 8'h00;
    for (int j = 0; j < 2; j++) begin
      int k = 2 * (a % 32) + j;
      int c = m[0] ? cell_of(k % 8, k / 8, 1'b1, q) : cell_of(k / 8, k % 8, 1'b0, q);
      logic [3:0] n = (c < 0) ? 4'h0 : ((a >= 128) ? ff0[c] : comb_val(c));
      if (j == 0) b[3:0] = n; else b[7:4] = n;
    end
    return b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(int a, logic [1:0] m, logic [1:0] q, string req, int anchor = -1);
    logic [7:0] e;
    @(negedge clk);
    addr = 8'(a); mode = m; quarter = q; rd = 1'b1;
    e = exp_byte(a, m, q);
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata, (anchor >= 0) ? anchor : e);
  endtask

  task automatic wr_do(int a, logic [1:0] m, logic [1:0] q, logic [7:0] d,
                       int n_exp, string req);
    @(negedge clk);
    addr = 8'(a); mode = m; quarter = q; wdata = d; wr = 1'b1;
    #1;
    chk(req, $countones(ld), n_exp);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", rdata, 8'h00);
    chk("R11", ld, 0);
  endtask

  task automatic t_single_probe;
    rd_chk(9, 2'b00, 2'b00, "R3", 8'h79);
    rd_chk(0, 2'b00, 2'b00, "R3");
    rd_chk(63, 2'b00, 2'b00, "R3");
    rd_chk(0, 2'b01, 2'b01, "R6", 8'hE9);
    rd_chk(0, 2'b00, 2'b10, "R6", 8'h69);
    rd_chk(27, 2'b00, 2'b10, "R6");
  endtask

  task automatic t_hpair;
    rd_chk(8'h05, 2'b10, 2'b00, "R4", 8'hBA);
    rd_chk(8'h85, 2'b10, 2'b00, "R4", 8'h54);
    rd_chk(8'h01, 2'b10, 2'b01, "R4");
    rd_chk(8'h9F, 2'b10, 2'b00, "R4");
  endtask

  task automatic t_vpair;
    rd_chk(8'h05, 2'b11, 2'b00, "R5", 8'h70);
    rd_chk(8'h85, 2'b11, 2'b00, "R5", 8'h77);
    rd_chk(8'h00, 2'b11, 2'b01, "R6", 8'h09);
    rd_chk(8'h83, 2'b11, 2'b10, "R6");
  endtask

  task automatic t_single_write;
    wr_do(9, 2'b00, 2'b00, 8'hF3, 1, "R7");
    chk("R7", ff0[17], 4'h3);
    rd_chk(9, 2'b00, 2'b00, "R7", 8'h39);
    wr_do(9, 2'b01, 2'b00, 8'h0C, 1, "R7");
    chk("R7", ff1[17], 4'hC);
    rd_chk(9, 2'b00, 2'b00, "R7", 8'h39);
  endtask

  task automatic t_pair_write;
    wr_do(8'h05, 2'b10, 2'b00, 8'hC4, 2, "R8");
    chk("R8", {ff0[19], ff0[18]}, 8'hC4);
    rd_chk(8'h85, 2'b10, 2'b00, "R8", 8'hC4);
    wr_do(8'h85, 2'b10, 2'b00, 8'h21, 2, "R8");
    chk("R8", {ff1[19], ff1[18]}, 8'h21);
    rd_chk(8'h85, 2'b10, 2'b00, "R8", 8'hC4);
    wr_do(8'h05, 2'b11, 2'b00, 8'h5A, 2, "R8");
    chk("R8", {ff0[49], ff0[33]}, 8'h5A);
  endtask

  task automatic t_absent;
    wr_do(8'h20, 2'b00, 2'b11, 8'hFF, 0, "R9");
    rd_chk(8'h20, 2'b00, 2'b11, "R9", 8'h00);
    wr_do(8'h04, 2'b00, 2'b01, 8'hFF, 0, "R9");
    rd_chk(8'h04, 2'b00, 2'b01, "R9", 8'h00);
    rd_chk(8'h82, 2'b10, 2'b01, "R9", 8'h00);
    chk("R9", ff0[12], init_val(12));
  endtask

  task automatic t_range;
    wr_do(8'h40, 2'b00, 2'b00, 8'hAA, 0, "R10");
    rd_chk(8'h40, 2'b00, 2'b00, "R10", 8'h00);
    wr_do(8'h20, 2'b10, 2'b00, 8'hAA, 0, "R10");
    rd_chk(8'hA0, 2'b11, 2'b00, "R10", 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] e_old;
    @(negedge clk);
    addr = 8'd9; mode = 2'b00; quarter = 2'b00; wdata = 8'h0E; rd = 1'b1; wr = 1'b1;
    e_old = exp_byte(9, 2'b00, 2'b00);
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    chk("R2", rdata, e_old);
    chk("R11", ff0[17], 4'hE);
    addr = 8'd0;
    @(negedge clk);
    chk("R2", rdata, e_old);
    rd_chk(9, 2'b00, 2'b00, "R2", 8'hE9);
  endtask

  task automatic t_no_wr;
    @(negedge clk);
    addr = 8'd3; mode = 2'b10; wdata = 8'h77; wr = 1'b0;
    #1;
    chk("R11", ld, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; mode = '0; quarter = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single_probe();
    t_hpair();
    t_vpair();
    t_single_write();
    t_pair_write();
    t_absent();
    t_range();
    t_collide();
    t_no_wr();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule